// File: doc/BRIEF.md
# Two-Operand Rotate, Logic and Min/Max Unit

This unit is a purely combinational execution slice for a 64-bit datapath. It takes two operands, A and B, plus a 4-bit operation code, and returns a 64-bit result in the same cycle. It provides these operations:

- Rotates in both directions, in double-word (64-bit) and word (32-bit) forms.
- A swapped-role right rotate, where B is the value and A is the amount.
- Three inverted bitwise operations.
- Signed and unsigned maximum and minimum.

An immediate amount is presented on operand B by the surrounding decode logic. Word-form results are always sign-extended from bit 31 of the rotated word.

Three internal pieces sit behind a shared operand-steering stage and an output select. The first is a logarithmic right rotator, instantiated at 64 and at 32 bits, which performs left rotates by negating the amount. The second is a bitwise unit and the third is an ordering unit.

Top module: `rotlog_unit`

## Requirements
- R1: Code 0 rotates A left by B mod 64; only B[5:0] affects the result.
- R2: Code 1 rotates A right by B mod 64; only B[5:0] affects the result.
- R3: The word rotates work on A[31:0] and use B mod 32 as the amount. Code 2 rotates left and code 3 rotates right. Result bits 63:32 all equal bit 31 of the rotated word.
- R4: The swapped right rotates take B as the value and A as the amount. Code 4 is the 64-bit form and uses A mod 64. Code 5 is the word form: it uses B[31:0] and A mod 32, and sign-extends from bit 31.
- R5: Code 6 returns A AND NOT B per bit; code 7 returns A OR NOT B per bit.
- R6: Code 8 returns NOT (A XOR B) per bit.
- R7: Signed comparisons use two's complement.
  - Code 9 returns A only when A > B; otherwise it returns B.
  - Code 11 returns A only when A < B; otherwise it returns B.
- R8: Unsigned comparisons follow the same rule as R7.
  - Code 10 returns A only when A > B; otherwise it returns B.
  - Code 12 returns A only when A < B; otherwise it returns B.
- R9: Codes 13, 14 and 15 return all zeros.
- R10: A rotate amount of zero returns the value unchanged for 64-bit forms. For word forms it returns the sign-extended low word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B (also carries immediate amounts) |
| res_o | output | 64 | Result |

## Verification
A rotate and a min/max can coincide in one vector: the steering stage routes A and B to the rotators while the ordering unit compares the very same operands. Random vectors make both paths see values with bit 63 and bit 31 set. Only the selected path may reach the result, and each sample is judged against a bench model of that operation alone. Directed vectors add pairs whose signed and unsigned orders disagree, and amounts at and just past the 32 and 64 wrap points.

// File: rtl/rotlog_pkg.sv
package rotlog_pkg;

    typedef enum logic [3:0] {
        OP_ROL_D  = 4'd0,
        OP_ROR_D  = 4'd1,
        OP_ROL_W  = 4'd2,
        OP_ROR_W  = 4'd3,
        OP_RORX_D = 4'd4,
        OP_RORX_W = 4'd5,
        OP_ANDN   = 4'd6,
        OP_ORN    = 4'd7,
        OP_XNOR   = 4'd8,
        OP_MAX    = 4'd9,
        OP_MAXU   = 4'd10,
        OP_MIN    = 4'd11,
        OP_MINU   = 4'd12
    } op_e;

    typedef struct packed {
        logic swap;
        logic left;
    } rot_ctrl_t;

endpackage

// File: rtl/rotlog_rotr.sv
module rotlog_rotr #(
    parameter int W = 64
) (
    input  logic [W-1:0]         val_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  logic                 left_i,
    output logic [W-1:0]         res_o
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] eff_amt;
    logic [W-1:0]  stg [SW+1];

    // Left rotate by n equals right rotate by (W - n) mod W.
    always_comb begin
        eff_amt = left_i ? (SW'(0) - amt_i) : amt_i;
    end

    assign stg[0] = val_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = eff_amt[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
    end

    assign res_o = stg[SW];

    // R1 R2: a rotate never creates or destroys set bits
    always_comb begin
        if (!$isunknown({val_i, amt_i, left_i}))
            a_r2_bits_kept: assert ($countones(res_o) == $countones(val_i))
                else $error("rotate changed population count");
    end

endmodule

// File: rtl/rotlog_bitwise.sv
module rotlog_bitwise #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] andn_o,
    output logic [W-1:0] orn_o,
    output logic [W-1:0] xnor_o
);
    always_comb begin
        andn_o = a_i & ~b_i;
        orn_o  = a_i | ~b_i;
        xnor_o = ~(a_i ^ b_i);
    end

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            a_r5_andn_clears_b: assert ((andn_o & b_i) == '0)
                else $error("andn kept a bit set in B");
            a_r5_orn_fills: assert ((orn_o | b_i) == '1)
                else $error("orn left a hole");
            a_r6_xnor_parity: assert ((xnor_o ^ a_i ^ b_i) == '1)
                else $error("xnor mismatch");
        end
    end

endmodule

// File: rtl/rotlog_order.sv
module rotlog_order #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] max_s_o,
    output logic [W-1:0] min_s_o,
    output logic [W-1:0] max_u_o,
    output logic [W-1:0] min_u_o
);
    logic gt_s, lt_s, gt_u, lt_u;

    always_comb begin
        gt_s = $signed(a_i) > $signed(b_i);
        lt_s = $signed(a_i) < $signed(b_i);
        gt_u = a_i > b_i;
        lt_u = a_i < b_i;
        max_s_o = gt_s ? a_i : b_i;
        min_s_o = lt_s ? a_i : b_i;
        max_u_o = gt_u ? a_i : b_i;
        min_u_o = lt_u ? a_i : b_i;
    end

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            a_r7_signed_order: assert ($signed(max_s_o) >= $signed(min_s_o))
                else $error("signed max below signed min");
            a_r8_unsigned_order: assert (max_u_o >= min_u_o)
                else $error("unsigned max below unsigned min");
            a_r7_pick_operand: assert ((max_s_o == a_i || max_s_o == b_i) &&
                                       (min_s_o == a_i || min_s_o == b_i))
                else $error("signed select not an operand");
        end
    end

endmodule

// File: rtl/rotlog_unit.sv
module rotlog_unit
    import rotlog_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o
);
    localparam int WLEN = XLEN / 2;
    localparam int SD   = $clog2(XLEN);
    localparam int SWD  = $clog2(WLEN);

    rot_ctrl_t        ctrl;
    logic [XLEN-1:0]  val_d;
    logic [SD-1:0]    amt_d;
    logic [WLEN-1:0]  val_w;
    logic [SWD-1:0]   amt_w;
    logic [XLEN-1:0]  rot_d;
    logic [WLEN-1:0]  rot_w;
    logic [XLEN-1:0]  rot_w_ext;
    logic [XLEN-1:0]  andn_r, orn_r, xnor_r;
    logic [XLEN-1:0]  max_s, min_s, max_u, min_u;

    // Operand steering for the rotators
    always_comb begin
        ctrl.swap = (op_i == OP_RORX_D) || (op_i == OP_RORX_W);
        ctrl.left = (op_i == OP_ROL_D)  || (op_i == OP_ROL_W);
        val_d = ctrl.swap ? b_i : a_i;
        amt_d = ctrl.swap ? a_i[SD-1:0] : b_i[SD-1:0];
        val_w = ctrl.swap ? b_i[WLEN-1:0] : a_i[WLEN-1:0];
        amt_w = ctrl.swap ? a_i[SWD-1:0] : b_i[SWD-1:0];
    end

    rotlog_rotr #(.W(XLEN)) i_rot_d (
        .val_i  (val_d),
        .amt_i  (amt_d),
        .left_i (ctrl.left),
        .res_o  (rot_d)
    );

    rotlog_rotr #(.W(WLEN)) i_rot_w (
        .val_i  (val_w),
        .amt_i  (amt_w),
        .left_i (ctrl.left),
        .res_o  (rot_w)
    );

    assign rot_w_ext = {{(XLEN-WLEN){rot_w[WLEN-1]}}, rot_w};

    rotlog_bitwise #(.W(XLEN)) i_bitwise (
        .a_i    (a_i),
        .b_i    (b_i),
        .andn_o (andn_r),
        .orn_o  (orn_r),
        .xnor_o (xnor_r)
    );

    rotlog_order #(.W(XLEN)) i_order (
        .a_i     (a_i),
        .b_i     (b_i),
        .max_s_o (max_s),
        .min_s_o (min_s),
        .max_u_o (max_u),
        .min_u_o (min_u)
    );

    // Result select
    always_comb begin
        case (op_i)
            OP_ROL_D, OP_ROR_D, OP_RORX_D: res_o = rot_d;
            OP_ROL_W, OP_ROR_W, OP_RORX_W: res_o = rot_w_ext;
            OP_ANDN: res_o = andn_r;
            OP_ORN:  res_o = orn_r;
            OP_XNOR: res_o = xnor_r;
            OP_MAX:  res_o = max_s;
            OP_MAXU: res_o = max_u;
            OP_MIN:  res_o = min_s;
            OP_MINU: res_o = min_u;
            default: res_o = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_i, a_i, b_i})) begin
            if (op_i == OP_ROL_W || op_i == OP_ROR_W || op_i == OP_RORX_W)
                a_r3_word_sext: assert (res_o[XLEN-1:WLEN-1] == '0 ||
                                        res_o[XLEN-1:WLEN-1] == '1)
                    else $error("word result not sign-extended");
            if (op_i > 4'd12)
                a_r9_unused_zero: assert (res_o == '0)
                    else $error("unused code gave nonzero result");
            if (op_i == OP_MAXU || op_i == OP_MINU)
                a_r8_pick_operand: assert (res_o == a_i || res_o == b_i)
                    else $error("unsigned select not an operand");
        end
    end

endmodule

// File: tb/test_rotlog_unit.sv
module test_rotlog_unit;

    logic        clk = 1'b0;
    logic [3:0]  op;
    logic [63:0] a, b;
    logic [63:0] res;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rotlog_unit i_rotlog_unit (
        .op_i  (op),
        .a_i   (a),
        .b_i   (b),
        .res_o (res)
    );

    function automatic logic [63:0] ror64(logic [63:0] v, int s);
        logic [63:0] r = v;
        for (int i = 0; i < s; i++) r = {r[0], r[63:1]};
        return r;
    endfunction

    function automatic logic [63:0] wext(logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [31:0] ror32(logic [31:0] v, int s);
        logic [31:0] r = v;
        for (int i = 0; i < s; i++) r = {r[0], r[31:1]};
        return r;
    endfunction

    function automatic logic [63:0] model(logic [3:0] o, logic [63:0] x, logic [63:0] y);
        int sd = int'(y[5:0]);
        int sw = int'(y[4:0]);
        case (o)
            4'd0:  return ror64(x, (64 - sd) % 64);
            4'd1:  return ror64(x, sd);
            4'd2:  return wext(ror32(x[31:0], (32 - sw) % 32));
            4'd3:  return wext(ror32(x[31:0], sw));
            4'd4:  return ror64(y, int'(x[5:0]));
            4'd5:  return wext(ror32(y[31:0], int'(x[4:0])));
            4'd6:  return x & ~y;
            4'd7:  return x | ~y;
            4'd8:  return ~(x ^ y);
            4'd9:  return ($signed(x) > $signed(y)) ? x : y;
            4'd10: return (x > y) ? x : y;
            4'd11: return ($signed(x) < $signed(y)) ? x : y;
            4'd12: return (x < y) ? x : y;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag(logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5: return "R4";
            4'd6, 4'd7: return "R5";
            4'd8: return "R6";
            4'd9, 4'd11: return "R7";
            4'd10, 4'd12: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [63:0] x,
                         input logic [63:0] y, input string req);
        logic [63:0] exp;
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        exp = model(o, x, y);
        n_vec++;
        if (res !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     req, o, x, y, res, exp);
        end
    endtask

    initial begin
        op = 4'd15; a = '0; b = '0;
        void'($urandom(32'h5eed_1234));
        // reset-like idle state: unused code yields zero (R9)
        apply(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, "R9");
        apply(4'd13, 64'hDEAD_BEEF_0000_0001, 64'h5, "R9");
        apply(4'd14, 64'h8000_0000_8000_0000, 64'hFFFF, "R9");
        // zero amounts (R10)
        apply(4'd0, 64'h8123_4567_89AB_CDEF, 64'h0, "R10");
        apply(4'd1, 64'h8123_4567_89AB_CDEF, 64'h100, "R10");
        apply(4'd3, 64'h0000_0000_8000_0001, 64'h40, "R10");
        apply(4'd5, 64'h20, 64'h1111_1111_F000_000F, "R10");
        // wrap points of amounts
        apply(4'd0, 64'h8000_0000_0000_0001, 64'd65, "R1");
        apply(4'd1, 64'h0000_0000_0000_0003, 64'd63, "R2");
        apply(4'd2, 64'hFFFF_FFFF_4000_0000, 64'd33, "R3");
        apply(4'd3, 64'h0000_0000_0000_0001, 64'd1, "R3");
        apply(4'd2, 64'h0000_0000_0000_0001, 64'd31, "R3");
        apply(4'd4, 64'd64, 64'h0123_4567_89AB_CDEF, "R4");
        apply(4'd4, 64'd8, 64'h0123_4567_89AB_CDEF, "R4");
        apply(4'd5, 64'd36, 64'h0000_0000_0000_00F0, "R4");
        // bitwise
        apply(4'd6, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, "R5");
        apply(4'd7, 64'h0, 64'hAAAA_5555_AAAA_5555, "R5");
        apply(4'd8, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, "R6");
        // signed vs unsigned disagreement, and ties
        apply(4'd9,  64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R7");
        apply(4'd11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R7");
        apply(4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R8");
        apply(4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R8");
        apply(4'd9,  64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R7");
        apply(4'd9,  64'h42, 64'h42, "R7");
        apply(4'd12, 64'h42, 64'h42, "R8");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  o = 4'($urandom_range(0, 15));
            logic [63:0] x = {$urandom, $urandom};
            logic [63:0] y = {$urandom, $urandom};
            if (i % 4 == 0) y[63:32] = x[63:32];
            apply(o, x, y, tag(o));
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule